// File: doc/BRIEF.md
# Separate-Port Burst-of-Two Static Memory

This block is a synthesizable, scaled-down model of a quad-data-rate style static memory. Writes enter only on a dedicated write port and reads leave only on a dedicated read port, so the two never share a data bus and never need a turnaround. Every access moves a burst of two words. The double-rate transfer is modelled inside one clock domain by carrying both words side by side as lane 0 (the first word) and lane 1 (the second word).

Storage is two equal banks indexed by the same address. Bank 0 holds lane 0 and bank 1 holds lane 1. The address bus is time-shared: within one cycle the bus gives a read-phase sample and a write-phase sample, and these appear as two address inputs. All controls, addresses and write data are registered before use, and read data leaves through an output register. A latency-mode input is captured while reset is held. It picks a read latency of two cycles (mode high) or one cycle (mode low).

Top module: `sepport_b2_sram`

## Requirements
- R1: A write-only access never raises `rd_valid_o` and leaves `rd_q0_o`/`rd_q1_o` unchanged. A read and a write to different addresses can be accepted on the same edge, and both complete.
- R2: Lane 0 of a write (`wr_d0_i`) is returned on `rd_q0_o` and lane 1 (`wr_d1_i`) on `rd_q1_o`, both stored under the same address.
- R3: A read is accepted when `rd_sel_n_i` is low at a rising clock edge. The read address is `addr_rd_i` sampled on that edge, and `addr_wr_i` plays no part in it.
- R4: With the captured mode high, `rd_valid_o` and the read words appear after the second rising edge following the accepting edge, and not earlier.
- R5: With the captured mode low, `rd_valid_o` and the read words appear after the first rising edge following the accepting edge.
- R6: Byte selects are active low. Bit i of `wr_bs_n0_i`/`wr_bs_n1_i` covers bits [9i+8:9i] of lane 0/lane 1. A byte whose select is high keeps its stored value.
- R7: A write is accepted when `wr_sel_n_i` is low at a rising edge and is committed one edge later. A read accepted one edge before the write returns the old data, and any later read returns the new data.
- R8: A read accepted on the same edge as a write to the same address returns the new write data, merged byte by byte with the stored data.
- R9: `rd_valid_o` is high for exactly one cycle per accepted read. Back-to-back reads give consecutive valid cycles, each carrying its own data.
- R10: `lat_mode_i` is used only while reset is asserted. Changing it after reset does not change the latency.
- R11: During and after reset, with no read issued, `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lat_mode_i | input | 1 | Latency mode, captured during reset: 1 = two cycles, 0 = one cycle |
| rd_sel_n_i | input | 1 | Active-low read port select |
| wr_sel_n_i | input | 1 | Active-low write port select |
| addr_rd_i | input | ADDR_W | Read-phase sample of the shared address bus |
| addr_wr_i | input | ADDR_W | Write-phase sample of the shared address bus |
| wr_d0_i | input | BYTES*9 | Write data, burst lane 0 |
| wr_d1_i | input | BYTES*9 | Write data, burst lane 1 |
| wr_bs_n0_i | input | BYTES | Active-low byte selects, lane 0 |
| wr_bs_n1_i | input | BYTES | Active-low byte selects, lane 1 |
| rd_q0_o | output | BYTES*9 | Read data, burst lane 0 |
| rd_q1_o | output | BYTES*9 | Read data, burst lane 1 |
| rd_valid_o | output | 1 | High in the cycle both read words are valid |

## Verification
The bench builds the block with the default ADDR_W=4 and BYTES=2: sixteen two-lane locations of two 9-bit bytes per word. This keeps every location easy to reach and makes address collisions easy to force. With two bytes per word, one write can update one byte and keep the other in each lane, so the per-byte merge on both the commit path and the same-edge bypass path can be observed. The block is reset once with each mode value, so both read latencies and the frozen-mode behaviour are exercised over the same storage.

// File: rtl/sepport_b2_pkg.sv
package sepport_b2_pkg;
  // Burst length is fixed by the access protocol: two words per access.
  localparam int unsigned BURST_LANES = 2;
  // Each byte lane carries 8 data bits plus one extra bit.
  localparam int unsigned LANE_BYTE_W = 9;
endpackage

// File: rtl/sepport_b2_rstsync.sv
module sepport_b2_rstsync (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= 2'b00;
    else           sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/sepport_b2_bank.sv
module sepport_b2_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTES  = 2,
  parameter int unsigned BYTE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         waddr_i,
  input  logic [BYTES*BYTE_W-1:0]   wdata_i,
  input  logic [BYTES-1:0]          wbe_i,
  input  logic [ADDR_W-1:0]         raddr_i,
  output logic [BYTES*BYTE_W-1:0]   rdata_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = BYTES * BYTE_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wbe_i[b]) mem[waddr_i][b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata_o = mem[raddr_i];

  for (genvar b = 0; b < BYTES; b++) begin : g_chk
    AST_BYTE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n_i)
      we_i && wbe_i[b] |=> mem[$past(waddr_i)][b*BYTE_W +: BYTE_W] == $past(wdata_i[b*BYTE_W +: BYTE_W])); // R7
    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n_i)
      we_i && !wbe_i[b] |=> mem[$past(waddr_i)][b*BYTE_W +: BYTE_W] == $past(mem[waddr_i][b*BYTE_W +: BYTE_W])); // R6
  end
endmodule

// File: rtl/sepport_b2_rdpipe.sv
module sepport_b2_rdpipe #(
  parameter int unsigned DW = 36
) (
  input  logic          clk,
  input  logic          rst_n_i,
  input  logic          mode_i,
  input  logic          vld_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [DW-1:0] data_o
);
  logic          s1_vld_q, s2_vld_q, s2_vld_d;
  logic [DW-1:0] s1_data_q, s2_data_q, s2_data_d;

  // Mode high inserts the extra stage; mode low feeds the output stage directly.
  always_comb begin
    s2_vld_d  = mode_i ? s1_vld_q  : vld_i;
    s2_data_d = mode_i ? s1_data_q : data_i;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_vld_q <= 1'b0;
      s2_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= vld_i;
      s2_vld_q <= s2_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i)    s1_data_q <= data_i;
    if (s2_vld_d) s2_data_q <= s2_data_d;
  end

  assign vld_o  = s2_vld_q;
  assign data_o = s2_data_q;

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n_i)
    vld_o == (mode_i ? $past(vld_i, 2) : $past(vld_i))); // R9
endmodule

// File: rtl/sepport_b2_sram.sv
module sepport_b2_sram
  import sepport_b2_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lat_mode_i,
  input  logic                          rd_sel_n_i,
  input  logic                          wr_sel_n_i,
  input  logic [ADDR_W-1:0]             addr_rd_i,
  input  logic [ADDR_W-1:0]             addr_wr_i,
  input  logic [BYTES*LANE_BYTE_W-1:0]  wr_d0_i,
  input  logic [BYTES*LANE_BYTE_W-1:0]  wr_d1_i,
  input  logic [BYTES-1:0]              wr_bs_n0_i,
  input  logic [BYTES-1:0]              wr_bs_n1_i,
  output logic [BYTES*LANE_BYTE_W-1:0]  rd_q0_o,
  output logic [BYTES*LANE_BYTE_W-1:0]  rd_q1_o,
  output logic                          rd_valid_o
);
  localparam int unsigned WORD_W = BYTES * LANE_BYTE_W;
  localparam int unsigned BUS_W  = BURST_LANES * WORD_W;

  logic rst_n_s;
  logic mode_q;
  logic rd_acc_q, wr_acc_q;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_d, wr_addr_q, wr_addr_d;
  logic [BURST_LANES-1:0][WORD_W-1:0] wr_data_q, wr_data_d, arr_rd, rd_merged;
  logic [BURST_LANES-1:0][BYTES-1:0]  wr_be_n_q, wr_be_n_d;
  logic byp_hit;
  logic [BUS_W-1:0] rd_out;

  sepport_b2_rstsync u_rst (.clk(clk), .arst_n_i(rst_n), .rst_n_o(rst_n_s));

  // Latency mode is captured only while the internal reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n_s) mode_q <= lat_mode_i;
  end

  // Next-state for input registers: each holds unless its port select is active.
  always_comb begin
    rd_addr_d = rd_addr_q;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    wr_be_n_d = wr_be_n_q;
    if (!rd_sel_n_i) rd_addr_d = addr_rd_i;
    if (!wr_sel_n_i) begin
      wr_addr_d    = addr_wr_i;
      wr_data_d[0] = wr_d0_i;
      wr_data_d[1] = wr_d1_i;
      wr_be_n_d[0] = wr_bs_n0_i;
      wr_be_n_d[1] = wr_bs_n1_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_acc_q  <= 1'b0;
      wr_acc_q  <= 1'b0;
      rd_addr_q <= '0;
      wr_addr_q <= '0;
      wr_be_n_q <= '1;
    end else begin
      rd_acc_q  <= !rd_sel_n_i;
      wr_acc_q  <= !wr_sel_n_i;
      rd_addr_q <= rd_addr_d;
      wr_addr_q <= wr_addr_d;
      wr_be_n_q <= wr_be_n_d;
    end
  end

  always_ff @(posedge clk) begin
    wr_data_q <= wr_data_d;
  end

  // A write accepted on the same edge as a read is still pending; forward it.
  assign byp_hit = wr_acc_q && (wr_addr_q == rd_addr_q);

  for (genvar g = 0; g < BURST_LANES; g++) begin : g_lane
    sepport_b2_bank #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(LANE_BYTE_W)) u_bank (
      .clk     (clk),
      .rst_n_i (rst_n_s),
      .we_i    (wr_acc_q),
      .waddr_i (wr_addr_q),
      .wdata_i (wr_data_q[g]),
      .wbe_i   (~wr_be_n_q[g]),
      .raddr_i (rd_addr_q),
      .rdata_o (arr_rd[g])
    );
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign rd_merged[g][b*LANE_BYTE_W +: LANE_BYTE_W] =
        (byp_hit && !wr_be_n_q[g][b]) ? wr_data_q[g][b*LANE_BYTE_W +: LANE_BYTE_W]
                                      : arr_rd[g][b*LANE_BYTE_W +: LANE_BYTE_W];
    end
  end

  sepport_b2_rdpipe #(.DW(BUS_W)) u_pipe (
    .clk     (clk),
    .rst_n_i (rst_n_s),
    .mode_i  (mode_q),
    .vld_i   (rd_acc_q),
    .data_i  (rd_merged),
    .vld_o   (rd_valid_o),
    .data_o  (rd_out)
  );

  assign rd_q0_o = rd_out[WORD_W-1:0];
  assign rd_q1_o = rd_out[BUS_W-1:WORD_W];

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> $stable(mode_q)); // R10
  AST_SAME_EDGE_FWD: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_acc_q && wr_acc_q && (rd_addr_q == wr_addr_q) && (wr_be_n_q == '0) && !mode_q
    |=> (rd_q0_o == $past(wr_data_q[0])) && (rd_q1_o == $past(wr_data_q[1]))); // R8
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_acc_q && !$past(rd_acc_q) |=> !rd_valid_o); // R11
endmodule

// File: tb/tb_sepport_b2_sram.sv
module tb_sepport_b2_sram;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int WW = NB * 9;

  logic clk = 1'b0;
  logic rst_n, lat_mode_i, rd_sel_n_i, wr_sel_n_i;
  logic [AW-1:0] addr_rd_i, addr_wr_i;
  logic [WW-1:0] wr_d0_i, wr_d1_i, rd_q0_o, rd_q1_o;
  logic [NB-1:0] wr_bs_n0_i, wr_bs_n1_i;
  logic rd_valid_o;

  int errors = 0;
  int checks = 0;
  int lat = 2;
  bit done = 1'b0;
  logic [WW-1:0] m0 [16];
  logic [WW-1:0] m1 [16];

  always #2 clk = ~clk;

  sepport_b2_sram #(.ADDR_W(AW), .BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .lat_mode_i(lat_mode_i),
    .rd_sel_n_i(rd_sel_n_i), .wr_sel_n_i(wr_sel_n_i),
    .addr_rd_i(addr_rd_i), .addr_wr_i(addr_wr_i),
    .wr_d0_i(wr_d0_i), .wr_d1_i(wr_d1_i),
    .wr_bs_n0_i(wr_bs_n0_i), .wr_bs_n1_i(wr_bs_n1_i),
    .rd_q0_o(rd_q0_o), .rd_q1_o(rd_q1_o), .rd_valid_o(rd_valid_o)
  );

  task automatic chk(input string req, input logic [2*WW-1:0] act, input logic [2*WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mrg(input logic [WW-1:0] old, input logic [WW-1:0] nw,
                                        input logic [NB-1:0] sel_n);
    logic [WW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (!sel_n[b]) r[b*9 +: 9] = nw[b*9 +: 9];
    return r;
  endfunction

  task automatic idle_inputs();
    rd_sel_n_i = 1'b1; wr_sel_n_i = 1'b1;
    addr_rd_i = '0; addr_wr_i = '0;
    wr_d0_i = '0; wr_d1_i = '0; wr_bs_n0_i = '1; wr_bs_n1_i = '1;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; lat_mode_i = mode; idle_inputs();
    repeat (4) @(negedge clk);
    chk("R11 valid in reset", {35'd0, rd_valid_o}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    lat = mode ? 2 : 1;
  endtask

  // One access; read expectation follows any same-edge write (R8).
  task automatic access(input bit rd, input int ra, input bit wr, input int wa,
                        input logic [WW-1:0] d0, input logic [WW-1:0] d1,
                        input logic [NB-1:0] b0, input logic [NB-1:0] b1, input string req);
    logic [2*WW-1:0] prevq, expq;
    @(negedge clk);
    prevq = {rd_q1_o, rd_q0_o};
    rd_sel_n_i = !rd; wr_sel_n_i = !wr;
    addr_rd_i = AW'(ra); addr_wr_i = rd ? AW'(ra + 1) : AW'(wa);
    if (wr) addr_wr_i = AW'(wa);
    if (!rd) addr_rd_i = AW'(wa + 3);
    wr_d0_i = d0; wr_d1_i = d1; wr_bs_n0_i = b0; wr_bs_n1_i = b1;
    if (wr) begin
      m0[wa] = mrg(m0[wa], d0, b0);
      m1[wa] = mrg(m1[wa], d1, b1);
    end
    expq = rd ? {m1[ra], m0[ra]} : prevq;
    @(negedge clk);
    idle_inputs();
    chk(lat == 2 ? "R4 not early" : "R5 not early", {35'd0, rd_valid_o}, '0);
    repeat (lat - 1) begin
      @(negedge clk);
      chk(lat == 2 ? "R4 not early" : "R5 not early", {35'd0, rd_valid_o}, '0);
    end
    @(negedge clk);
    chk({req, " valid"}, {35'd0, rd_valid_o}, {35'd0, rd});
    chk({req, " data"}, {rd_q1_o, rd_q0_o}, expq);
    @(negedge clk);
    chk("R9 single valid", {35'd0, rd_valid_o}, '0);
  endtask

  task automatic t_basic();
    access(0, 0, 1, 3, 18'h1A5C3, 18'h0F0F1, 2'b00, 2'b00, "R1 write only");
    access(0, 0, 1, 5, 18'h3FFFF, 18'h00001, 2'b00, 2'b00, "R1 write only");
    access(1, 3, 0, 0, '0, '0, 2'b11, 2'b11, lat == 2 ? "R4 R2 R3 read 3" : "R5 R2 R3 read 3");
    access(1, 5, 0, 0, '0, '0, 2'b11, 2'b11, "R2 R3 read 5");
    access(1, 3, 1, 9, 18'h2AAAA, 18'h15555, 2'b00, 2'b00, "R1 concurrent read");
    access(1, 9, 0, 0, '0, '0, 2'b11, 2'b11, "R1 concurrent write landed");
  endtask

  task automatic t_bytes();
    access(0, 0, 1, 3, 18'h3FE01, 18'h12345, 2'b01, 2'b10, "R6 masked write");
    access(1, 3, 0, 0, '0, '0, 2'b11, 2'b11, "R6 masked readback");
  endtask

  task automatic t_same_edge();
    access(0, 0, 1, 7, 18'h11111, 18'h22222, 2'b00, 2'b00, "R8 prep");
    access(1, 7, 1, 7, 18'h3CCCC, 18'h03333, 2'b10, 2'b01, "R8 same-edge merge");
    access(1, 7, 1, 7, 18'h0ABCD, 18'h1DCBA, 2'b00, 2'b00, "R8 same-edge full");
  endtask

  task automatic t_read_before_write();
    logic [2*WW-1:0] oldq;
    oldq = {m1[9], m0[9]};
    @(negedge clk);
    rd_sel_n_i = 1'b0; addr_rd_i = 4'd9; addr_wr_i = 4'd2;
    @(negedge clk);
    rd_sel_n_i = 1'b1; addr_rd_i = 4'd0;
    wr_sel_n_i = 1'b0; addr_wr_i = 4'd9; wr_d0_i = 18'h00777; wr_d1_i = 18'h38888;
    wr_bs_n0_i = 2'b00; wr_bs_n1_i = 2'b00;
    m0[9] = 18'h00777; m1[9] = 18'h38888;
    @(negedge clk);
    idle_inputs();
    repeat (lat - 1) @(negedge clk);
    chk("R7 earlier read valid", {35'd0, rd_valid_o}, 36'd1);
    chk("R7 earlier read old data", {rd_q1_o, rd_q0_o}, oldq);
    @(negedge clk);
    access(1, 9, 0, 0, '0, '0, 2'b11, 2'b11, "R7 later read new data");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    rd_sel_n_i = 1'b0; addr_rd_i = 4'd3;
    @(negedge clk);
    addr_rd_i = 4'd5;
    @(negedge clk);
    idle_inputs();
    repeat (lat - 1) @(negedge clk);
    chk("R9 first valid", {35'd0, rd_valid_o}, 36'd1);
    chk("R9 first data", {rd_q1_o, rd_q0_o}, {m1[3], m0[3]});
    @(negedge clk);
    chk("R9 second valid", {35'd0, rd_valid_o}, 36'd1);
    chk("R9 second data", {rd_q1_o, rd_q0_o}, {m1[5], m0[5]});
    @(negedge clk);
    chk("R9 valid drops", {35'd0, rd_valid_o}, '0);
  endtask

  task automatic t_mode_frozen();
    @(negedge clk);
    lat_mode_i = ~lat_mode_i;
    access(1, 5, 0, 0, '0, '0, 2'b11, 2'b11, "R10 latency unchanged");
  endtask

  initial begin
    rst_n = 1'b0; lat_mode_i = 1'b1; idle_inputs();
    do_reset(1'b1);
    repeat (3) begin
      @(negedge clk);
      chk("R11 idle after reset", {35'd0, rd_valid_o}, '0);
    end
    t_basic();
    t_bytes();
    t_same_edge();
    t_read_before_write();
    t_back_to_back();
    t_mode_frozen();
    do_reset(1'b0);
    t_basic();
    t_bytes();
    t_same_edge();
    t_read_before_write();
    t_back_to_back();
    t_mode_frozen();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule